// File: doc/BRIEF.md
# Rollback History Buffer

This block keeps a record of every instruction in flight, in the order the instructions were issued, so that results may be written back out of order while exceptions stay precise. At issue, each instruction takes one slot, branches included. The slot holds the value the destination register had before the instruction could change it. Execution units later report each slot as done, either cleanly or with a fault. Slots leave the buffer strictly from the oldest end. A slot leaves only when its instruction has completed cleanly and every older slot has already left.

When the oldest slot carries a fault, or when an interrupt request arrives, the block stops taking new instructions and raises a one-cycle flush to the instruction queue. It then steps back from the youngest slot towards the oldest. In each step it hands the saved register value to the register file through a restore write port, one slot per cycle. When the last slot has been undone, it raises a one-cycle vector request that tells the sequencer which kind of event, fault or interrupt, caused the recovery. The register file is outside this block.

The depth must be a power of two, because the pointers wrap naturally.

Top module: `hist_buf`

## Requirements
- R1: Slots are handed out in sequence: `alloc_tag` shows the tag the next accepted allocation receives, and it advances by one modulo DEPTH on each accepted allocation. With DEPTH live slots, `alloc_ready` is low and an offered allocation is dropped without moving `alloc_tag`.
- R2: Instructions may finish in any order. `retire_valid` with `retire_tag` names at most one slot per cycle. Slots retire in tag order. A slot retires only after it has finished without a fault and all older slots have retired.
- R3: A slot that finished with a fault never retires. When it becomes the oldest slot, `flush` is high for exactly one cycle, and the next cycle starts the recovery walk.
- R4: The recovery walk visits the live slots from youngest to oldest, faulting slot included, one slot per cycle. A slot allocated with `alloc_we`=1 produces `restore_we`=1 with its saved index and value. A slot with `alloc_we`=0 uses its cycle but writes nothing. After the walk, `alloc_tag` equals the tag of the oldest undone slot.
- R5: `vec_req` is high for one cycle, in the cycle after the last slot is walked. `vec_irq` is 0 when a fault caused the recovery and 1 when an interrupt caused it.
- R6: `irq_req` high while no recovery is running takes priority over retirement. It undoes every live slot and gives `vec_irq`=1. With an empty buffer it gives `flush`, then `vec_req` in the following cycle.
- R7: `alloc_ready` is low in the flush cycle and throughout the walk. Allocations offered then are dropped.
- R8: After reset the buffer is empty, `alloc_ready`=1, `alloc_tag`=0, and `retire_valid`, `flush`, `restore_we` and `vec_req` are all 0.
- R9: A faulting oldest slot takes priority over a simultaneous `irq_req`, and the recovery reports `vec_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Offer a new instruction |
| alloc_we | input | 1 | Instruction writes a register |
| alloc_idx | input | RIDX_W | Destination register index |
| alloc_old | input | XLEN | Register value before the instruction |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_tag | output | TAG_W | Tag of the next slot |
| finish_valid | input | 1 | An execution unit reports completion |
| finish_tag | input | TAG_W | Slot being completed |
| finish_exc | input | 1 | Completion carries a fault |
| irq_req | input | 1 | External interrupt request |
| retire_valid | output | 1 | Oldest slot retires this cycle |
| retire_tag | output | TAG_W | Tag of the retiring slot |
| flush | output | 1 | Flush the instruction queue |
| restore_we | output | 1 | Write a saved value back |
| restore_idx | output | RIDX_W | Register index to restore |
| restore_val | output | XLEN | Value to restore |
| vec_req | output | 1 | Recovery complete, take the vector |
| vec_irq | output | 1 | Recovery was caused by an interrupt |

## Verification
The bench finishes slots out of order, including the oldest slot last. A design that retired whatever had finished would emit tags out of sequence or too early. It fills the buffer and offers one more allocation. A design with a broken full test would overwrite the oldest slot, which shows up as a wrong tag or an extra retirement. It puts a faulting slot behind a cleanly finished one and a non-writing slot inside the walk. A walk in the wrong direction, a restore write for a non-writing slot, or a walk that skips the faulting slot shows up as a misordered or mismatched restore. It also raises an interrupt in the same cycle a retirement is ready, on an empty buffer, and together with a fault. A wrong priority would retire a slot, lose the flush, or report the wrong vector cause.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic {
        HB_RUN  = 1'b0,
        HB_UNDO = 1'b1
    } hb_mode_e;
endpackage

// File: rtl/hb_onehot.sv
module hb_onehot #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic         en,
    input  logic [W-1:0] sel,
    output logic [N-1:0] hot
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign hot[i] = en && (sel == W'(i));
    end
endmodule

// File: rtl/hist_buf.sv
module hist_buf
    import hb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_we,
    input  logic [RIDX_W-1:0] alloc_idx,
    input  logic [XLEN-1:0]   alloc_old,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              finish_valid,
    input  logic [TAG_W-1:0]  finish_tag,
    input  logic              finish_exc,
    input  logic              irq_req,
    output logic              retire_valid,
    output logic [TAG_W-1:0]  retire_tag,
    output logic              flush,
    output logic              restore_we,
    output logic [RIDX_W-1:0] restore_idx,
    output logic [XLEN-1:0]   restore_val,
    output logic              vec_req,
    output logic              vec_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        hb_mode_e                      mode;
        logic [TAG_W-1:0]              head;
        logic [TAG_W-1:0]              tail;
        logic [CNT_W-1:0]              cnt;
        logic [DEPTH-1:0]              vld;
        logic [DEPTH-1:0]              fin;
        logic [DEPTH-1:0]              exc;
        logic [DEPTH-1:0]              we;
        logic [DEPTH-1:0][RIDX_W-1:0]  idx;
        logic [DEPTH-1:0][XLEN-1:0]    old;
        logic                          cause_irq;
        logic                          vec;
        logic                          vec_irq;
    } hb_state_t;

    hb_state_t st_d, st_q;

    logic [DEPTH-1:0] fin_hot, alc_hot;
    logic [TAG_W-1:0] walk;
    logic             run, live, exc_start, irq_start, start, retire_ok, alloc_go;
    logic [CNT_W-1:0] cnt_q;
    logic             undo_q;

    // oldest-slot status and event priority: fault > interrupt > retire
    assign run       = (st_q.mode == HB_RUN);
    assign live      = (st_q.cnt != '0);
    assign walk      = st_q.tail - 1'b1;
    assign exc_start = run && live && st_q.fin[st_q.head] && st_q.exc[st_q.head];
    assign irq_start = run && irq_req && !exc_start;
    assign start     = exc_start || irq_start;
    assign retire_ok = run && !start && live && st_q.fin[st_q.head] && !st_q.exc[st_q.head];
    assign alloc_ready = run && !start && (st_q.cnt != CNT_W'(DEPTH));
    assign alloc_go  = alloc_valid && alloc_ready;

    hb_onehot #(.N(DEPTH), .W(TAG_W)) u_fin_hot (
        .en (finish_valid),
        .sel(finish_tag),
        .hot(fin_hot)
    );

    hb_onehot #(.N(DEPTH), .W(TAG_W)) u_alc_hot (
        .en (alloc_go),
        .sel(st_q.tail),
        .hot(alc_hot)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vec = 1'b0;

        for (int i = 0; i < DEPTH; i++) begin
            if (fin_hot[i] && st_q.vld[i]) begin
                st_d.fin[i] = 1'b1;
                st_d.exc[i] = finish_exc;
            end
        end

        if (run) begin
            if (retire_ok) begin
                st_d.vld[st_q.head] = 1'b0;
                st_d.fin[st_q.head] = 1'b0;
                st_d.exc[st_q.head] = 1'b0;
                st_d.head           = st_q.head + 1'b1;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (alc_hot[i]) begin
                    st_d.vld[i] = 1'b1;
                    st_d.fin[i] = 1'b0;
                    st_d.exc[i] = 1'b0;
                    st_d.we[i]  = alloc_we;
                    st_d.idx[i] = alloc_idx;
                    st_d.old[i] = alloc_old;
                end
            end
            if (alloc_go) begin
                st_d.tail = st_q.tail + 1'b1;
            end
            st_d.cnt = st_q.cnt + CNT_W'(alloc_go) - CNT_W'(retire_ok);
            if (start) begin
                if (live) begin
                    st_d.mode      = HB_UNDO;
                    st_d.cause_irq = irq_start;
                end else begin
                    st_d.vec     = 1'b1;
                    st_d.vec_irq = irq_start;
                end
            end
        end else begin
            // undo the youngest slot this cycle
            st_d.vld[walk] = 1'b0;
            st_d.fin[walk] = 1'b0;
            st_d.exc[walk] = 1'b0;
            st_d.tail      = walk;
            st_d.cnt       = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.mode    = HB_RUN;
                st_d.vec     = 1'b1;
                st_d.vec_irq = st_q.cause_irq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_tag    = st_q.tail;
    assign retire_valid = retire_ok;
    assign retire_tag   = st_q.head;
    assign flush        = start;
    assign restore_we   = !run && st_q.we[walk];
    assign restore_idx  = st_q.idx[walk];
    assign restore_val  = st_q.old[walk];
    assign vec_req      = st_q.vec;
    assign vec_irq      = st_q.vec_irq;

    assign cnt_q  = st_q.cnt;
    assign undo_q = !run;
endmodule

// File: rtl/hist_buf_chk.sv
module hist_buf_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             retire_valid,
    input logic             flush,
    input logic             restore_we,
    input logic             vec_req,
    input logic [CNT_W-1:0] cnt,
    input logic             in_undo
);
    p_cnt_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(DEPTH)) |-> !alloc_ready);

    p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retire_valid, flush, restore_we}));

    p_flush_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && cnt != '0) |=> in_undo);

    p_walk_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_undo |=> (32'(cnt) + 1 == 32'($past(cnt))));

    p_vec_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (($past(in_undo) && !in_undo) || $past(flush)));

    p_flush_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_ready);

    p_walk_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_undo |-> (!alloc_ready && !retire_valid));
endmodule

bind hist_buf hist_buf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .retire_valid(retire_valid),
    .flush       (flush),
    .restore_we  (restore_we),
    .vec_req     (vec_req),
    .cnt         (cnt_q),
    .in_undo     (undo_q)
);

// File: tb/test_hist_buf.sv
`timescale 1ns/1ps
module test_hist_buf;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0, alloc_we = 1'b0;
    logic [4:0] alloc_idx = '0;
    logic [31:0] alloc_old = '0;
    logic       alloc_ready;
    logic [2:0] alloc_tag;
    logic       finish_valid = 1'b0, finish_exc = 1'b0, irq_req = 1'b0;
    logic [2:0] finish_tag = '0;
    logic       retire_valid, flush, restore_we, vec_req, vec_irq;
    logic [2:0] retire_tag;
    logic [4:0] restore_idx;
    logic [31:0] restore_val;

    hist_buf i_hist_buf (
        .clk, .rst_n, .alloc_valid, .alloc_we, .alloc_idx, .alloc_old,
        .alloc_ready, .alloc_tag, .finish_valid, .finish_tag, .finish_exc,
        .irq_req, .retire_valid, .retire_tag, .flush, .restore_we,
        .restore_idx, .restore_val, .vec_req, .vec_irq
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [63:0] expq[$];

    // event word: kind (1 retire, 2 flush, 3 restore, 4 vector), field, value
    function automatic logic [63:0] ev(int k, int a, int v);
        return {8'(k), 8'(a), 16'h0, 32'(v)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic take(logic [63:0] got, string req);
        logic [63:0] e;
        if (expq.size() == 0) begin
            chk(1'b0, req, "unexpected event", got, 64'h0);
        end else begin
            e = expq.pop_front();
            chk(got == e, req, "event mismatch", got, e);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (retire_valid) take(ev(1, retire_tag, 0), "R2");
            if (flush) begin
                take(ev(2, 0, 0), "R3");
                chk(!alloc_ready, "R7", "ready in flush cycle", alloc_ready, 0);
            end
            if (restore_we) begin
                take(ev(3, restore_idx, restore_val), "R4");
                chk(!alloc_ready, "R7", "ready during walk", alloc_ready, 0);
            end
            if (vec_req) take(ev(4, vec_irq, 0), "R5");
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(bit we, int idx, int val, int exp_tag);
        alloc_valid = 1'b1;
        alloc_we    = we;
        alloc_idx   = 5'(idx);
        alloc_old   = 32'(val);
        @(negedge clk);
        chk(alloc_ready && alloc_tag == 3'(exp_tag), "R1", "alloc tag", alloc_tag, exp_tag);
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic do_fin(int tag, bit exc);
        finish_valid = 1'b1;
        finish_tag   = 3'(tag);
        finish_exc   = exc;
        step();
        finish_valid = 1'b0;
        finish_exc   = 1'b0;
    endtask

    task automatic drain(string req);
        for (int i = 0; i < 40 && expq.size() != 0; i++) step();
        repeat (3) step();
        chk(expq.size() == 0, req, "missing events", expq.size(), 0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(alloc_ready && alloc_tag == 0, "R8", "ready/tag", {alloc_ready, alloc_tag}, 64'h8);
        chk(!retire_valid && !flush && !restore_we && !vec_req, "R8", "idle outputs",
            {retire_valid, flush, restore_we, vec_req}, 0);
        step();

        // R2 out-of-order finish, in-order retire
        for (int i = 0; i < 4; i++) do_alloc(i != 2, i + 1, 'h100 + i, i);
        for (int i = 0; i < 4; i++) expq.push_back(ev(1, i, 0));
        do_fin(3, 0); do_fin(1, 0); do_fin(0, 0); do_fin(2, 0);
        drain("R2");

        // R1 full buffer
        for (int i = 0; i < 8; i++) do_alloc(1'b1, 2, 'h50 + i, (4 + i) % 8);
        @(negedge clk);
        chk(!alloc_ready, "R1", "ready when full", alloc_ready, 0);
        alloc_valid = 1'b1; alloc_idx = 5'd9; alloc_old = 32'hdead;
        step();
        alloc_valid = 1'b0;
        for (int i = 0; i < 8; i++) expq.push_back(ev(1, (4 + i) % 8, 0));
        for (int i = 7; i >= 0; i--) do_fin((4 + i) % 8, 0);
        drain("R1");
        @(negedge clk);
        chk(alloc_tag == 4, "R1", "tag after dropped alloc", alloc_tag, 4);
        step();

        // R3/R4/R5 fault recovery with a non-writing slot inside the walk
        for (int i = 0; i < 5; i++) do_alloc(i != 2, 10 + i, 'h200 + i, (4 + i) % 8);
        expq.push_back(ev(1, 4, 0));
        expq.push_back(ev(2, 0, 0));
        expq.push_back(ev(3, 14, 'h204));
        expq.push_back(ev(3, 13, 'h203));
        expq.push_back(ev(3, 11, 'h201));
        expq.push_back(ev(4, 0, 0));
        do_fin(4, 0); do_fin(7, 0); do_fin(5, 1);
        // R7 allocations offered during flush and walk are dropped
        alloc_valid = 1'b1; alloc_we = 1'b1; alloc_idx = 5'd30; alloc_old = 32'hbad;
        repeat (5) step();
        alloc_valid = 1'b0;
        drain("R4");
        @(negedge clk);
        chk(alloc_tag == 5, "R4", "tag after walk", alloc_tag, 5);
        step();

        // R6 interrupt beats a ready retirement
        for (int i = 0; i < 3; i++) do_alloc(1'b1, 20 + i, 'h300 + i, 5 + i);
        expq.push_back(ev(2, 0, 0));
        expq.push_back(ev(3, 22, 'h302));
        expq.push_back(ev(3, 21, 'h301));
        expq.push_back(ev(3, 20, 'h300));
        expq.push_back(ev(4, 1, 0));
        do_fin(5, 0);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        drain("R6");
        @(negedge clk);
        chk(alloc_tag == 5, "R6", "tag after interrupt walk", alloc_tag, 5);
        step();

        // R6 interrupt on an empty buffer
        expq.push_back(ev(2, 0, 0));
        expq.push_back(ev(4, 1, 0));
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        drain("R6");

        // R9 fault and interrupt together
        do_alloc(1'b1, 25, 'h400, 5);
        expq.push_back(ev(2, 0, 0));
        expq.push_back(ev(3, 25, 'h400));
        expq.push_back(ev(4, 0, 0));
        do_fin(5, 1);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        drain("R9");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule